// File: doc/BRIEF.md
# Hot-Plug Expander Link Controller

This block keeps the hot-plug signals of several downstream ports in step with an external I/O expander that sits on a shared SMBus master. A register file supplies the current hot-plug output image. Whenever any bit of that image changes, the block issues one write that carries the whole image. When the expander pulls one of its active-low interrupt lines, the block issues one read of the whole input image. It then publishes the result on an input status vector together with a one-cycle update strobe.

The block does not drive SMBus bit timing. It talks to a byte-level master engine that is shared with other agents. It requests the bus, waits for a grant, starts one transaction and waits for the engine to report completion with an acknowledge flag and, for reads, the received data. Nothing is issued until the enable input rises after reset-time configuration. Output changes seen before that are remembered and flushed once the enable is high.

Top module: `hpexp_ctrl`

## Requirements
- R1: After reset, `bus_req`, `txn_start`, `hp_in_upd` and `rd_err` are 0 and `hp_in_stat` is all zeros.
- R2: While `cfg_done` is 0, `bus_req` never rises. An output change made during that time is still sent as one write once `cfg_done` becomes 1.
- R3: A change of `hp_out_vec` causes exactly one transaction with `txn_write` = 1 and `txn_wdata` equal to the full current image.
- R4: Output changes made while a transaction is in flight are merged. Exactly one further write follows, and it carries the latest image.
- R5: Any one of the `NUM_INT` interrupt lines held at 0 causes a transaction with `txn_write` = 0. On an acknowledged read, `hp_in_stat` takes `txn_rdata` and `hp_in_upd` is high for exactly one cycle.
- R6: If an interrupt line is still 0 when a read completes, another read is issued. Reads continue until the line returns to 1.
- R7: When a write and a read are both pending at grant time, the write is performed first.
- R8: A read that completes with `txn_ack` = 0 is retried up to `MAX_RETRY` (default 3) times. If the last retry also fails, `rd_err` becomes 1, no update strobe is given and `hp_in_stat` keeps its previous value. The next acknowledged read clears `rd_err`.
- R9: Interrupt lines pass through a two-flop synchronizer. From an idle state with nothing pending, `bus_req` is still 0 after the second rising edge following a line falling, and it is 1 after the third.
- R10: `txn_start` is a single-cycle pulse that occurs only while `bus_req` is 1. `bus_req` falls only in the cycle after `txn_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_done | input | 1 | Enable, raised once reset-time configuration has finished |
| hp_out_vec | input | OUT_W | Hot-plug output image from the register file |
| exp_int_n | input | NUM_INT | Active-low expander interrupt lines, asynchronous |
| bus_req | output | 1 | Request for the shared SMBus master |
| bus_gnt | input | 1 | Grant of the shared SMBus master |
| txn_start | output | 1 | One-cycle start of a transaction |
| txn_write | output | 1 | 1 for a write of the output image, 0 for a read of the input image |
| txn_wdata | output | OUT_W | Output image carried by a write |
| txn_done | input | 1 | One-cycle completion from the master engine |
| txn_ack | input | 1 | Acknowledge status, valid with `txn_done` |
| txn_rdata | input | IN_W | Input image returned by a read, valid with `txn_done` |
| hp_in_stat | output | IN_W | Last successfully read hot-plug input image |
| hp_in_upd | output | 1 | One-cycle strobe when `hp_in_stat` is refreshed |
| rd_err | output | 1 | Set when a read exhausts its retries |

## Verification
The hardest state to reach is a write and a read both pending at the moment the grant arrives. With a free bus, either one launches before the other can build up. The bench holds the grant low, pulls an interrupt line and changes the output image, and waits long enough for the synchronizer to settle. It then releases the grant and inspects the order of the logged transactions. Retry exhaustion is reached in a similar way: the bus model refuses acknowledges for a programmed number of reads and lets the interrupt go at the first read.

// File: rtl/hpexp_pkg.sv
package hpexp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_XFER = 2'd2
  } hpexp_state_e;
endpackage

// File: rtl/hpexp_sync.sv
module hpexp_sync #(
  parameter int W       = 3,
  parameter bit RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;

  for (genvar i = 0; i < W; i++) begin : g_line
    always_ff @(posedge clk) begin
      if (rst) begin
        stage1[i] <= RST_VAL;
        d_sync[i] <= RST_VAL;
      end else begin
        stage1[i] <= d_async[i];
        d_sync[i] <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/hpexp_outtrack.sv
module hpexp_outtrack #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] img,
  input  logic         launch_wr,
  output logic         wr_pend
);
  logic [W-1:0] last_img;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_img <= '0;
      wr_pend  <= 1'b0;
    end else begin
      last_img <= img;
      wr_pend  <= (wr_pend & ~launch_wr) | (img != last_img);
    end
  end
endmodule

// File: rtl/hpexp_rdstat.sv
module hpexp_rdstat #(
  parameter int IN_W      = 8,
  parameter int MAX_RETRY = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rd_done,
  input  logic            rd_ack,
  input  logic [IN_W-1:0] rd_data,
  output logic [IN_W-1:0] stat,
  output logic            upd,
  output logic            err,
  output logic            retry_pend
);
  localparam int CW = $clog2(MAX_RETRY + 1);

  logic [CW-1:0] retry_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat       <= '0;
      upd        <= 1'b0;
      err        <= 1'b0;
      retry_pend <= 1'b0;
      retry_cnt  <= '0;
    end else begin
      upd <= 1'b0;
      if (rd_done) begin
        if (rd_ack) begin
          stat       <= rd_data;
          upd        <= 1'b1;
          err        <= 1'b0;
          retry_cnt  <= '0;
          retry_pend <= 1'b0;
        end else if (retry_cnt == CW'(MAX_RETRY)) begin
          err        <= 1'b1;
          retry_cnt  <= '0;
          retry_pend <= 1'b0;
        end else begin
          retry_cnt  <= retry_cnt + 1'b1;
          retry_pend <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/hpexp_seq.sv
module hpexp_seq
  import hpexp_pkg::*;
#(
  parameter int OUT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_done,
  input  logic             wr_pend,
  input  logic             rd_need,
  input  logic [OUT_W-1:0] img,
  input  logic             bus_gnt,
  input  logic             txn_done,
  output logic             bus_req,
  output logic             txn_start,
  output logic             txn_write,
  output logic [OUT_W-1:0] txn_wdata,
  output logic             launch_wr,
  output logic             rd_done
);
  hpexp_state_e state;

  assign launch_wr = (state == ST_REQ) && bus_gnt && wr_pend;
  assign rd_done   = (state == ST_XFER) && txn_done && !txn_write;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      bus_req   <= 1'b0;
      txn_start <= 1'b0;
      txn_write <= 1'b0;
      txn_wdata <= '0;
    end else begin
      txn_start <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (cfg_done && (wr_pend || rd_need)) begin
            bus_req <= 1'b1;
            state   <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (bus_gnt) begin
            txn_start <= 1'b1;
            txn_write <= wr_pend;
            if (wr_pend) txn_wdata <= img;
            state <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (txn_done) begin
            bus_req <= 1'b0;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hpexp_ctrl.sv
module hpexp_ctrl #(
  parameter int OUT_W     = 8,
  parameter int IN_W      = 8,
  parameter int NUM_INT   = 3,
  parameter int MAX_RETRY = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_done,
  input  logic [OUT_W-1:0]   hp_out_vec,
  input  logic [NUM_INT-1:0] exp_int_n,
  output logic               bus_req,
  input  logic               bus_gnt,
  output logic               txn_start,
  output logic               txn_write,
  output logic [OUT_W-1:0]   txn_wdata,
  input  logic               txn_done,
  input  logic               txn_ack,
  input  logic [IN_W-1:0]    txn_rdata,
  output logic [IN_W-1:0]    hp_in_stat,
  output logic               hp_in_upd,
  output logic               rd_err
);
  logic [NUM_INT-1:0] int_s;
  logic               int_any;
  logic               wr_pend;
  logic               retry_pend;
  logic               launch_wr;
  logic               rd_done;

  hpexp_sync #(.W(NUM_INT), .RST_VAL(1'b1)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (exp_int_n),
    .d_sync  (int_s)
  );

  assign int_any = |(~int_s);

  hpexp_outtrack #(.W(OUT_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .img       (hp_out_vec),
    .launch_wr (launch_wr),
    .wr_pend   (wr_pend)
  );

  hpexp_rdstat #(.IN_W(IN_W), .MAX_RETRY(MAX_RETRY)) u_rd (
    .clk        (clk),
    .rst        (rst),
    .rd_done    (rd_done),
    .rd_ack     (txn_ack),
    .rd_data    (txn_rdata),
    .stat       (hp_in_stat),
    .upd        (hp_in_upd),
    .err        (rd_err),
    .retry_pend (retry_pend)
  );

  hpexp_seq #(.OUT_W(OUT_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cfg_done  (cfg_done),
    .wr_pend   (wr_pend),
    .rd_need   (int_any | retry_pend),
    .img       (hp_out_vec),
    .bus_gnt   (bus_gnt),
    .txn_done  (txn_done),
    .bus_req   (bus_req),
    .txn_start (txn_start),
    .txn_write (txn_write),
    .txn_wdata (txn_wdata),
    .launch_wr (launch_wr),
    .rd_done   (rd_done)
  );
endmodule

// File: rtl/hpexp_ctrl_chk.sv
module hpexp_ctrl_chk #(
  parameter int IN_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            cfg_done,
  input logic            bus_req,
  input logic            txn_start,
  input logic            txn_done,
  input logic [IN_W-1:0] txn_rdata,
  input logic [IN_W-1:0] hp_in_stat,
  input logic            hp_in_upd
);
  AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> $past(cfg_done)); // R2
  AST_UPD_CARRIES_DATA: assert property (@(posedge clk) disable iff (rst)
    hp_in_upd |-> (hp_in_stat == $past(txn_rdata))); // R5
  AST_UPD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    hp_in_upd |=> !hp_in_upd); // R5
  AST_STAT_HELD: assert property (@(posedge clk) disable iff (rst)
    !hp_in_upd |-> $stable(hp_in_stat)); // R8
  AST_START_OWNED: assert property (@(posedge clk) disable iff (rst)
    txn_start |-> bus_req); // R10
  AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
    txn_start |=> !txn_start); // R10
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req) |-> $past(txn_done)); // R10
endmodule

bind hpexp_ctrl hpexp_ctrl_chk #(.IN_W(IN_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cfg_done   (cfg_done),
  .bus_req    (bus_req),
  .txn_start  (txn_start),
  .txn_done   (txn_done),
  .txn_rdata  (txn_rdata),
  .hp_in_stat (hp_in_stat),
  .hp_in_upd  (hp_in_upd)
);

// File: tb/hpexp_ctrl_bench.sv
module hpexp_ctrl_bench;
  localparam int OUT_W = 8;
  localparam int IN_W  = 8;
  localparam int NI    = 3;

  logic clk = 1'b0;
  logic rst;
  logic cfg_done;
  logic [OUT_W-1:0] hp_out_vec;
  logic [NI-1:0] exp_int_n;
  logic bus_req, bus_gnt, txn_start, txn_write, txn_done, txn_ack;
  logic [OUT_W-1:0] txn_wdata;
  logic [IN_W-1:0] txn_rdata, hp_in_stat;
  logic hp_in_upd, rd_err;

  always #4 clk = ~clk;

  hpexp_ctrl u_hpexp_ctrl (
    .clk(clk), .rst(rst), .cfg_done(cfg_done), .hp_out_vec(hp_out_vec),
    .exp_int_n(exp_int_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .txn_start(txn_start), .txn_write(txn_write), .txn_wdata(txn_wdata),
    .txn_done(txn_done), .txn_ack(txn_ack), .txn_rdata(txn_rdata),
    .hp_in_stat(hp_in_stat), .hp_in_upd(hp_in_upd), .rd_err(rd_err)
  );

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  // stimulus-side controls (written by tasks only)
  logic [NI-1:0] pull_v = '0;
  int  pull_gen = 0;
  int  cfg_gen = 0;
  int  cfg_lat = 4, cfg_nack = 0, cfg_rel = 0;
  bit  cfg_rel_any = 0;
  bit  gnt_block = 0;
  logic [IN_W-1:0] rd_val = '0;

  // bus model state (written by the model only)
  int  rel_gen = 0;
  int  seen_cfg = -1;
  int  lat, nack_left, rel_cnt;
  bit  rel_any;
  int  nwr = 0, nrd = 0, nupd = 0, ntx = 0;
  logic [OUT_W-1:0] last_wd = '0;
  bit  kind [0:255];
  bit  busy = 0, cur_wr = 0;
  int  cnt = 0;

  assign exp_int_n = (rel_gen == pull_gen) ? '1 : ~pull_v;

  initial begin
    bus_gnt = 1'b0; txn_done = 1'b0; txn_ack = 1'b0; txn_rdata = '0;
    forever begin
      @(negedge clk);
      if (cfg_gen != seen_cfg) begin
        seen_cfg = cfg_gen; lat = cfg_lat; nack_left = cfg_nack;
        rel_cnt = cfg_rel; rel_any = cfg_rel_any;
      end
      if (hp_in_upd) nupd++;
      txn_done = 1'b0;
      if (busy) begin
        if (cnt == 0) begin
          busy = 0; txn_done = 1'b1;
          if (cur_wr) txn_ack = 1'b1;
          else if (nack_left > 0) begin txn_ack = 1'b0; nack_left--; end
          else begin txn_ack = 1'b1; txn_rdata = rd_val; end
        end else cnt--;
      end else if (txn_start) begin
        busy = 1; cnt = lat; cur_wr = txn_write;
        kind[ntx & 255] = txn_write; ntx++;
        if (txn_write) begin nwr++; last_wd = txn_wdata; end
        else begin
          nrd++;
          if (rel_cnt > 0 && (nack_left == 0 || rel_any)) begin
            rel_cnt--;
            if (rel_cnt == 0) rel_gen = pull_gen;
          end
        end
      end
      bus_gnt = bus_req & ~gnt_block;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_model(input int l, input int nk, input int rl, input bit ra);
    cfg_lat = l; cfg_nack = nk; cfg_rel = rl; cfg_rel_any = ra;
    cfg_gen++;
    repeat (2) @(negedge clk);
  endtask

  task automatic pull(input logic [NI-1:0] v);
    pull_v = v;
    pull_gen++;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1; cfg_done = 1'b0; hp_out_vec = '0;
    settle(3);
    rst = 1'b0;
    @(negedge clk);
    chk(bus_req == 1'b0, "R1 bus_req", bus_req, 0);
    chk(txn_start == 1'b0, "R1 txn_start", txn_start, 0);
    chk(hp_in_upd == 1'b0, "R1 hp_in_upd", hp_in_upd, 0);
    chk(rd_err == 1'b0, "R1 rd_err", rd_err, 0);
    chk(hp_in_stat == '0, "R1 hp_in_stat", hp_in_stat, 0);
  endtask

  task automatic t_disabled;
    set_model(4, 0, 0, 0);
    hp_out_vec = 8'h5A;
    pull(3'b001);
    settle(40);
    chk(nwr + nrd == 0 && bus_req == 1'b0, "R2 quiet while disabled", nwr + nrd, 0);
    pull('0);
    settle(5);
    cfg_done = 1'b1;
    settle(30);
    chk(nwr == 1, "R2 deferred write count", nwr, 1);
    chk(last_wd == 8'h5A, "R2 deferred write image", last_wd, 8'h5A);
  endtask

  task automatic t_single_write;
    int b = nwr;
    int r = nrd;
    hp_out_vec = 8'hA3;
    settle(30);
    chk(nwr == b + 1 && nrd == r, "R3 one write", nwr - b, 1);
    chk(last_wd == 8'hA3, "R3 full image", last_wd, 8'hA3);
  endtask

  task automatic t_merge;
    int b = nwr;
    set_model(20, 0, 0, 0);
    hp_out_vec = 8'h11;
    while (nwr == b) @(negedge clk);
    hp_out_vec = 8'h22;
    @(negedge clk);
    hp_out_vec = 8'h3C;
    settle(80);
    chk(nwr == b + 2, "R4 merged write count", nwr - b, 2);
    chk(last_wd == 8'h3C, "R4 latest image", last_wd, 8'h3C);
    set_model(4, 0, 0, 0);
  endtask

  task automatic t_int_lines;
    for (int i = 0; i < NI; i++) begin
      int r = nrd;
      int u = nupd;
      logic [IN_W-1:0] v = IN_W'(8'h40 + i);
      rd_val = v;
      set_model(4, 0, 1, 0);
      pull(NI'(1) << i);
      settle(30);
      chk(nrd == r + 1 && nupd == u + 1, "R5 one read and strobe", nrd - r, 1);
      chk(hp_in_stat == v, "R5 status from read", hp_in_stat, v);
    end
  endtask

  task automatic t_repeat;
    int r = nrd;
    rd_val = 8'h77;
    set_model(4, 0, 3, 0);
    pull(3'b010);
    settle(60);
    chk(nrd == r + 3, "R6 reads while line low", nrd - r, 3);
    chk(hp_in_stat == 8'h77, "R6 status", hp_in_stat, 8'h77);
  endtask

  task automatic t_priority;
    int b = ntx;
    rd_val = 8'h99;
    set_model(4, 0, 1, 0);
    gnt_block = 1'b1;
    pull(3'b100);
    hp_out_vec = 8'hE1;
    settle(10);
    gnt_block = 1'b0;
    settle(40);
    chk(kind[b & 255] == 1'b1, "R7 write first", kind[b & 255], 1);
    chk(kind[(b + 1) & 255] == 1'b0 && ntx == b + 2, "R7 read second", ntx - b, 2);
  endtask

  task automatic t_retry;
    int r = nrd;
    int u = nupd;
    rd_val = 8'h5C;
    set_model(4, 3, 1, 0);
    pull(3'b001);
    settle(80);
    chk(nrd == r + 4, "R8 retried reads", nrd - r, 4);
    chk(nupd == u + 1 && hp_in_stat == 8'h5C, "R8 success after retries", hp_in_stat, 8'h5C);
    chk(rd_err == 1'b0, "R8 no error", rd_err, 0);
  endtask

  task automatic t_exhaust;
    int r = nrd;
    int u = nupd;
    logic [IN_W-1:0] keep = hp_in_stat;
    rd_val = 8'hC7;
    set_model(4, 4, 1, 1);
    pull(3'b010);
    settle(80);
    chk(nrd == r + 4, "R8 attempts before error", nrd - r, 4);
    chk(rd_err == 1'b1, "R8 error flag", rd_err, 1);
    chk(nupd == u && hp_in_stat == keep, "R8 status kept", hp_in_stat, keep);
    set_model(4, 0, 1, 0);
    pull(3'b010);
    settle(30);
    chk(rd_err == 1'b0 && hp_in_stat == 8'hC7, "R8 error cleared by good read", rd_err, 0);
  endtask

  task automatic t_sync;
    rd_val = 8'h0F;
    set_model(4, 0, 1, 0);
    settle(5);
    pull(3'b100);
    @(negedge clk);
    chk(bus_req == 1'b0, "R9 one edge", bus_req, 0);
    @(negedge clk);
    chk(bus_req == 1'b0, "R9 two edges", bus_req, 0);
    @(negedge clk);
    chk(bus_req == 1'b1, "R9 three edges", bus_req, 1);
    settle(30);
    chk(hp_in_stat == 8'h0F, "R10 handshake completes", hp_in_stat, 8'h0F);
  endtask

  initial begin
    t_reset;
    t_disabled;
    t_single_write;
    t_merge;
    t_int_lines;
    t_repeat;
    t_priority;
    t_retry;
    t_exhaust;
    t_sync;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule